// File: doc/BRIEF.md
# Floating-Point Register Stack File

This block holds the eight 80-bit working registers of a floating-point unit as a stack. A 3-bit top pointer rotates over the physical slots, and every access names an entry relative to the top: ST(0) is the top, and ST(i) is the entry i places below it. Values come in by a push and leave by a pop. An arithmetic unit outside the block reads its two operands here and writes its result back through the same write-data port. The block does no arithmetic.

The first operand is always ST(0), which acts as the accumulator. The second operand is ST(1) for the implicit two-operand form, an explicitly indexed ST(i), or a value arriving on a separate memory-operand port. A result can be written to any ST(i), with or without a pop in the same cycle. When it is written with a pop, the write lands before the top advances, so the result ends up one place higher. A single-cycle exchange swaps ST(0) with ST(i). This lets any entry serve as the accumulator.

Each physical slot carries an empty tag. Pushing onto an occupied slot raises overflow. Consuming an empty entry raises underflow. A faulting operation leaves every register, tag and the top pointer unchanged.

Top module: `fp_reg_stack`

## Requirements
- R1: After reset `top_o` is 0, `empty_o` is all ones, and `ovf_o` and `unf_o` are 0.
- R2: Opcode 1 (push) with the slot at (top-1) mod 8 empty does three things: it writes `wdata_i` into that slot, clears the slot's empty bit, and sets top to (top-1) mod 8.
- R3: A push whose target slot is occupied raises `ovf_o` for one cycle in the cycle after the edge, and changes no register, tag or top.
- R4: Opcode 2 (pop) with ST(0) occupied sets the empty bit of physical slot top and sets top to (top+1) mod 8. The stored value is left in place.
- R5: A pop of an empty ST(0) raises `unf_o` for one cycle and changes no state.
- R6: `opa_o` is always the value of ST(0). `opb_o` depends on `src_i`: ST(1) for 0, ST(`idx_i`) for 1, and `mem_i` for 2 or 3.
- R7: `opnd_fault_o` is high, combinationally, when ST(0) is empty or the selected stack operand for `opb_o` is empty. The memory operand never faults.
- R8: Opcode 3 (write) stores `wdata_i` into ST(`idx_i`) and marks it occupied. It changes top in no case and raises no flag.
- R9: Opcode 4 (write-and-pop) needs both ST(0) and ST(`idx_i`) occupied. It writes `wdata_i` into ST(`idx_i`), empties the old ST(0) and advances top by one, so a result for index i becomes the new ST(i-1). With index 0 the written entry is discarded. If either entry is empty, it raises `unf_o` and changes no state.
- R10: Opcode 5 (exchange) swaps the values of ST(0) and ST(`idx_i`) in one clock and keeps top and all tags. If either entry is empty, it raises `unf_o` and changes no state.
- R11: Bit p of `empty_o` is the tag of physical slot p. ST(i) maps to physical slot (top+i) mod 8. Opcodes 0, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 write, 4 write-and-pop, 5 exchange |
| idx_i | input | 3 | Relative index i of ST(i) |
| src_i | input | 2 | Second operand source: 0 ST(1), 1 ST(i), 2 or 3 memory |
| wdata_i | input | 80 | Push data or result data |
| mem_i | input | 80 | Memory operand |
| opa_o | output | 80 | ST(0) |
| opb_o | output | 80 | Selected second operand |
| opnd_fault_o | output | 1 | A selected stack operand is empty |
| top_o | output | 3 | Physical index of ST(0) |
| empty_o | output | 8 | Empty tag for each physical slot |
| ovf_o | output | 1 | Overflow from the previous operation |
| unf_o | output | 1 | Underflow from the previous operation |

## Verification
The assertions assume that `op_i` and `idx_i` are stable across the sampling edge. The movement checks on the top pointer also assume that the operands seen at the edge are the ones that decided the operation. The bench meets both conditions by changing inputs only on the falling edge.

Its stimulus runs in two parts:
- a directed sequence that fills the stack to overflow, exchanges entries, writes results and drains the stack past underflow;
- a long random run with a weighted mix of opcodes, so the top pointer wraps many times and every fault path is hit while slots are both occupied and empty.

Some dyadic results come from a stand-in adder, which sums the two operands the bench's own model predicts.

// File: rtl/fp_stack_pkg.sv
package fp_stack_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_WRITE = 3'd3,
    OP_WRPOP = 3'd4,
    OP_XCHG  = 3'd5
  } stk_op_e;

  typedef enum logic [1:0] {
    SRC_ST1 = 2'd0,
    SRC_STI = 2'd1,
    SRC_MEM = 2'd2
  } src_e;
endpackage

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fp_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [PW-1:0]    idx_i,
  input  logic [DEPTH-1:0] valid_i,
  output logic [PW-1:0]    top_o,
  output logic             wr_en_o,
  output logic [PW-1:0]    wr_addr_o,
  output logic             clr_en_o,
  output logic [PW-1:0]    clr_addr_o,
  output logic             swp_en_o,
  output logic [PW-1:0]    swp_b_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [PW-1:0] top_q, top_d;
  logic [PW-1:0] slot_i, slot_push;
  logic          ovf_d, unf_d, ovf_q, unf_q;
  stk_op_e       op;

  assign op        = stk_op_e'(op_i);
  assign slot_i    = top_q + idx_i;
  assign slot_push = top_q - PW'(1);

  always_comb begin
    top_d      = top_q;
    wr_en_o    = 1'b0;
    wr_addr_o  = slot_i;
    clr_en_o   = 1'b0;
    clr_addr_o = top_q;
    swp_en_o   = 1'b0;
    swp_b_o    = slot_i;
    ovf_d      = 1'b0;
    unf_d      = 1'b0;
    case (op)
      OP_PUSH: begin
        if (valid_i[slot_push]) ovf_d = 1'b1;
        else begin
          wr_en_o   = 1'b1;
          wr_addr_o = slot_push;
          top_d     = slot_push;
        end
      end
      OP_POP: begin
        if (!valid_i[top_q]) unf_d = 1'b1;
        else begin
          clr_en_o = 1'b1;
          top_d    = top_q + PW'(1);
        end
      end
      OP_WRITE: wr_en_o = 1'b1;
      OP_WRPOP: begin
        if (!valid_i[top_q] || !valid_i[slot_i]) unf_d = 1'b1;
        else begin
          wr_en_o  = 1'b1;
          clr_en_o = 1'b1;
          top_d    = top_q + PW'(1);
        end
      end
      OP_XCHG: begin
        if (!valid_i[top_q] || !valid_i[slot_i]) unf_d = 1'b1;
        else swp_en_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign top_o = top_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  a_r2_push_moves_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !valid_i[top_q - PW'(1)]) |=> (top_q == $past(top_q) - PW'(1)));

  a_r3_ovf_holds_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> $stable(top_q));

  a_r4_pop_moves_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && valid_i[top_q]) |=> (top_q == $past(top_q) + PW'(1)));

  a_r5_unf_holds_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> $stable(top_q));

  a_r10_xchg_keeps_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |=> $stable(top_q));
endmodule

// File: rtl/fp_stack_regs.sv
module fp_stack_regs #(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [PW-1:0]           wr_addr_i,
  input  logic [W-1:0]            wr_data_i,
  input  logic                    clr_en_i,
  input  logic [PW-1:0]           clr_addr_i,
  input  logic                    swp_en_i,
  input  logic [PW-1:0]           swp_a_i,
  input  logic [PW-1:0]           swp_b_i,
  output logic [DEPTH-1:0][W-1:0] val_o,
  output logic [DEPTH-1:0]        valid_o
);
  logic [DEPTH-1:0][W-1:0] val_q;
  logic [DEPTH-1:0]        valid_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic          hit_wr, hit_clr, hit_a, hit_b;
    logic [W-1:0]  val_d;
    logic          valid_d;

    assign hit_wr  = wr_en_i  && (wr_addr_i  == PW'(s));
    assign hit_clr = clr_en_i && (clr_addr_i == PW'(s));
    assign hit_a   = swp_en_i && (swp_a_i    == PW'(s));
    assign hit_b   = swp_en_i && (swp_b_i    == PW'(s));

    always_comb begin
      val_d   = val_q[s];
      valid_d = valid_q[s];
      if (hit_a)      val_d = val_q[swp_b_i];
      else if (hit_b) val_d = val_q[swp_a_i];
      if (hit_wr) begin
        val_d   = wr_data_i;
        valid_d = 1'b1;
      end
      // clear after write: write-and-pop at index 0 discards the result
      if (hit_clr) valid_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[s]   <= '0;
        valid_q[s] <= 1'b0;
      end else begin
        val_q[s]   <= val_d;
        valid_q[s] <= valid_d;
      end
    end
  end

  assign val_o   = val_q;
  assign valid_o = valid_q;

  a_r10_xchg_keeps_tags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swp_en_i && !wr_en_i && !clr_en_i) |=> $stable(valid_q));

  a_r8_write_sets_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_en_i) |=> valid_q[$past(wr_addr_i)]);

  a_r4_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |=> !valid_q[$past(clr_addr_i)]);
endmodule

// File: rtl/fp_stack_rdmux.sv
module fp_stack_rdmux
  import fp_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][W-1:0] val_i,
  input  logic [DEPTH-1:0]        valid_i,
  input  logic [PW-1:0]           top_i,
  input  logic [PW-1:0]           idx_i,
  input  logic [1:0]              src_i,
  input  logic [W-1:0]            mem_i,
  output logic [W-1:0]            opa_o,
  output logic [W-1:0]            opb_o,
  output logic                    fault_o
);
  logic [PW-1:0] b_addr;
  logic          from_mem;

  assign from_mem = src_i[1];
  assign b_addr   = (src_e'(src_i) == SRC_ST1) ? top_i + PW'(1) : top_i + idx_i;
  assign opa_o    = val_i[top_i];
  assign opb_o    = from_mem ? mem_i : val_i[b_addr];
  assign fault_o  = !valid_i[top_i] || (!from_mem && !valid_i[b_addr]);
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [PW-1:0]    idx_i,
  input  logic [1:0]       src_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     mem_i,
  output logic [W-1:0]     opa_o,
  output logic [W-1:0]     opb_o,
  output logic             opnd_fault_o,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] empty_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [DEPTH-1:0][W-1:0] val;
  logic [DEPTH-1:0]        valid;
  logic [PW-1:0]           top, wr_addr, clr_addr, swp_b;
  logic                    wr_en, clr_en, swp_en;

  fp_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .op_i, .idx_i,
    .valid_i(valid), .top_o(top),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .clr_en_o(clr_en), .clr_addr_o(clr_addr),
    .swp_en_o(swp_en), .swp_b_o(swp_b),
    .ovf_o, .unf_o
  );

  fp_stack_regs #(.DEPTH(DEPTH), .W(W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wdata_i),
    .clr_en_i(clr_en), .clr_addr_i(clr_addr),
    .swp_en_i(swp_en), .swp_a_i(top), .swp_b_i(swp_b),
    .val_o(val), .valid_o(valid)
  );

  fp_stack_rdmux #(.DEPTH(DEPTH), .W(W)) u_rdmux (
    .val_i(val), .valid_i(valid), .top_i(top), .idx_i, .src_i, .mem_i,
    .opa_o, .opb_o, .fault_o(opnd_fault_o)
  );

  assign top_o   = top;
  assign empty_o = ~valid;

  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

// File: tb/fp_reg_stack_tb.sv
module fp_reg_stack_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [2:0]  idx_i = '0;
  logic [1:0]  src_i = '0;
  logic [79:0] wdata_i = '0;
  logic [79:0] mem_i = '0;
  logic [79:0] opa_o, opb_o;
  logic        opnd_fault_o, ovf_o, unf_o;
  logic [2:0]  top_o;
  logic [7:0]  empty_o;

  fp_reg_stack u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  int vecs = 0, errs = 0;
  bit done = 0;

  logic [79:0] mv [8];
  bit          mt [8];
  int          mtop;
  bit          e_ovf, e_unf;

  function automatic int ph(int i);
    return (mtop + i) & 7;
  endfunction

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state();
    logic [7:0] ee;
    for (int p = 0; p < 8; p++) ee[p] = !mt[p];
    chk(top_o == 3'(mtop), "R2 R4 R11 top", 80'(top_o), 80'(mtop));
    chk(empty_o == ee, "R8 R11 empty tags", 80'(empty_o), 80'(ee));
    chk(ovf_o == e_ovf, "R3 overflow", 80'(ovf_o), 80'(e_ovf));
    chk(unf_o == e_unf, "R5 R9 R10 underflow", 80'(unf_o), 80'(e_unf));
  endtask

  task automatic predict(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] wd);
    int p0, pi, s;
    logic [79:0] t;
    p0 = ph(0); pi = ph(int'(idx)); s = (mtop + 7) & 7;
    e_ovf = 0; e_unf = 0;
    case (op)
      3'd1: if (mt[s]) e_ovf = 1; else begin mv[s] = wd; mt[s] = 1; mtop = s; end
      3'd2: if (!mt[p0]) e_unf = 1; else begin mt[p0] = 0; mtop = (mtop + 1) & 7; end
      3'd3: begin mv[pi] = wd; mt[pi] = 1; end
      3'd4: if (!mt[p0] || !mt[pi]) e_unf = 1;
            else begin mv[pi] = wd; mt[pi] = 1; mt[p0] = 0; mtop = (mtop + 1) & 7; end
      3'd5: if (!mt[p0] || !mt[pi]) e_unf = 1;
            else begin t = mv[p0]; mv[p0] = mv[pi]; mv[pi] = t; end
      default: ;
    endcase
  endtask

  // called just after a falling edge
  task automatic cyc(input logic [2:0] op, input logic [2:0] idx, input logic [1:0] src,
                     input logic [79:0] wd, input logic [79:0] mem, input bit add);
    int p0, pb;
    bit msel;
    logic [79:0] eb;
    check_state();
    p0 = ph(0);
    pb = (src == 2'd0) ? ph(1) : ph(int'(idx));
    msel = src[1];
    eb = msel ? mem : mv[pb];
    if (add) wd = mv[p0] + eb;  // stand-in dyadic unit
    op_i = op; idx_i = idx; src_i = src; wdata_i = wd; mem_i = mem;
    #1;
    chk(opa_o == mv[p0], "R6 opa is ST(0)", opa_o, mv[p0]);
    chk(opb_o == eb, "R6 opb select", opb_o, eb);
    chk(opnd_fault_o == (!mt[p0] || (!msel && !mt[pb])), "R7 operand fault",
        80'(opnd_fault_o), 80'(!mt[p0] || (!msel && !mt[pb])));
    predict(op, idx, wd);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog all requirements act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 8; p++) begin mv[p] = '0; mt[p] = 0; end
    mtop = 0; e_ovf = 0; e_unf = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk(top_o == 3'd0 && empty_o == 8'hff && !ovf_o && !unf_o, "R1 reset state",
        {69'd0, top_o, empty_o}, {69'd0, 3'd0, 8'hff});

    cyc(3'd2, 0, 0, 0, 0, 0);                       // R5 pop empty
    cyc(3'd5, 3, 1, 0, 0, 0);                       // R10 exchange on empty
    for (int k = 0; k < 8; k++) cyc(3'd1, 0, 0, rnd80(), 0, 0);  // R2 fill
    cyc(3'd1, 0, 0, rnd80(), 0, 0);                 // R3 overflow
    cyc(3'd0, 0, 0, 0, 0, 0);
    cyc(3'd5, 5, 1, 0, 0, 0);                       // R10 exchange
    cyc(3'd5, 0, 1, 0, 0, 0);                       // R10 self exchange
    cyc(3'd3, 0, 0, 0, 80'h1234, 1);                // R8 ST0 = ST0+ST1
    cyc(3'd3, 0, 2, 0, rnd80(), 1);                 // R6 memory operand
    cyc(3'd3, 6, 1, 0, 0, 1);                       // R8 explicit ST(i)
    cyc(3'd4, 1, 0, 0, 0, 1);                       // R9 write ST1 then pop
    cyc(3'd4, 3, 1, 0, 0, 1);                       // R9 other index
    cyc(3'd4, 0, 0, rnd80(), 0, 0);                 // R9 index 0 discards
    for (int k = 0; k < 6; k++) cyc(3'd2, 0, 0, 0, 0, 0);  // R4 drain
    cyc(3'd4, 1, 0, rnd80(), 0, 0);                 // R9 underflow
    cyc(3'd6, 2, 3, rnd80(), rnd80(), 0);           // R11 unused opcode
    cyc(3'd7, 2, 3, rnd80(), rnd80(), 0);
    cyc(3'd0, 0, 0, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom % 16);
      op = (r < 4) ? 3'd1 : (r < 7) ? 3'd2 : (r < 9) ? 3'd3 :
           (r < 11) ? 3'd4 : (r < 13) ? 3'd5 : 3'(r - 13 + 5);
      if (op == 3'd5) op = 3'd5;
      cyc(op, 3'($urandom), 2'($urandom), rnd80(), rnd80(), ($urandom % 2) == 1);
    end
    check_state();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule